// File: doc/BRIEF.md
# Boot-Block Sector Map with Write Lockout

This block turns a 19-bit word address of a two-plane flash array into the index of one of 22 erase sectors and the plane that holds it. Eight small sectors of mixed size (8K, 16K, four of 4K, 16K, 8K words) form plane A. Fourteen sectors of 32K words form plane B. A parameter sets which end of the address space holds the small sectors: the bottom-boot build places them at the low end, and the top-boot build places them at the high end.

Each sector has a sticky lock bit. Only a power-on reset clears these bits, so the ordinary reset leaves them in place. Every program, sector-erase and chip-erase request is checked against the lock bits. A high-voltage override input removes that check. In identification mode the block returns the manufacturer code, the device code or a sector's lock bit, chosen by the offset of the address within its sector.

Requests are single-cycle strobes. There is no back-pressure: the block accepts a request on every clock and answers one clock later, so the caller never waits. The timing of the erase itself belongs to a separate engine. That engine uses the erase mask and the quick-abort flag.

Top module: `flash_sector_guard`

## Requirements
- R1: In the bottom-boot build (TOP_BOOT=0), word addresses 00000-01FFF map to sector 0, 02000-05FFF to 1, 06000, 07000, 08000 and 09000 (4K each) to sectors 2-5, 0A000-0DFFF to 6, 0E000-0FFFF to 7, and each 32K block from 10000 up to sectors 8 through 21.
- R2: rsp_plane is 0 (plane A) for the eight small sectors and 1 (plane B) for the fourteen 32K sectors.
- R3: In the top-boot build (TOP_BOOT=1), addresses below 70000 map to sectors 0-13 in 32K steps on plane B. The small sectors 14-21 follow from 70000 with the same size order on plane A. The device code is 004A in this build and 00CB in the bottom-boot build.
- R4: A request strobe (req_valid=1) at one clock edge produces rsp_valid=1 after that edge, together with the sector index and plane of req_addr. A clock edge with no request leaves rsp_valid at 0.
- R5: Operation codes on req_op are 1 program, 2 sector erase, 3 chip erase, 4 lock set and 5 ID read. A lock set sets the addressed sector's bit and answers permit=1. Afterwards, program and sector erase to that sector answer permit=0, while other sectors still answer permit=1.
- R6: While hv_override=1, program and sector erase to a locked sector answer permit=1.
- R7: A chip erase answers with rsp_erase_mask holding bit i for every sector i that is unlocked (all 22 bits when hv_override=1). permit is 1 when that mask is non-zero.
- R8: A sector erase that is refused answers rsp_quick_abort=1 and a zero mask. A permitted sector erase answers a mask with only the sector's own bit set and quick_abort=0.
- R9: An ID read answers permit=0. rsp_id_data depends on the address offset within its sector (bits 11:0): offset 0 gives 001F, offset 1 gives the device code, offset 2 gives the sector's lock bit on bit 0 (1 = locked), and any other offset gives 0000.
- R10: Lock bits survive a pulse on rst_n and are cleared only by por_n.
- R11: While either reset is low, every response output is 0.
- R12: Codes 0, 6 and 7 answer permit=0 and a zero mask, and change no lock bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears lock bits and outputs |
| rst_n | input | 1 | Ordinary reset, active low; clears response outputs only |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 3 | Operation code (see R5) |
| req_addr | input | 19 | Word address |
| hv_override | input | 1 | Lockout override flag |
| rsp_valid | output | 1 | Response strobe, one clock after the request |
| rsp_sector | output | 5 | Decoded sector index |
| rsp_plane | output | 1 | 0 = plane A, 1 = plane B |
| rsp_permit | output | 1 | Request allowed |
| rsp_quick_abort | output | 1 | Sector erase refused; ends at once |
| rsp_erase_mask | output | 22 | Sectors an erase may clear |
| rsp_id_data | output | 16 | Identification-mode read value |

## Verification
A wrong decode shows up in the very next response. The sector index or plane is off, and only at the boundary addresses where the slice comparisons change. A lost or stray lock bit stays hidden until a later request touches that sector. It then appears as a wrong permit, a wrong chip-erase mask bit or a wrong bit 0 on an offset-2 ID read. The bench therefore reads the lock state back through ID reads right after each lock set, each ordinary reset and each power-on reset.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  localparam int NUM_SECTORS  = 22;
  localparam int SECT_IDX_W   = $clog2(NUM_SECTORS);
  localparam int WORD_ADDR_W  = 19;
  localparam int BIG_SECT_W   = 15;   // 32K-word sectors
  localparam int SMALL_AREA_W = 16;   // 64K-word area holding the small sectors
  localparam int ID_OFS_W     = 12;   // smallest sector is 4K words
  localparam int ID_W         = 16;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_SERASE = 3'd2,
    OP_CERASE = 3'd3,
    OP_LOCK   = 3'd4,
    OP_IDRD   = 3'd5
  } fsg_op_e;

  localparam logic [ID_W-1:0] MFR_CODE     = 16'h001F;
  localparam logic [ID_W-1:0] DEV_CODE_BOT = 16'h00CB;
  localparam logic [ID_W-1:0] DEV_CODE_TOP = 16'h004A;

  // Index of a small sector within its 64K-word area, from address bits 15:12.
  function automatic logic [2:0] small_slot(input logic [3:0] nib);
    logic [2:0] s;
    case (nib)
      4'h0, 4'h1:               s = 3'd0;
      4'h2, 4'h3, 4'h4, 4'h5:   s = 3'd1;
      4'h6:                     s = 3'd2;
      4'h7:                     s = 3'd3;
      4'h8:                     s = 3'd4;
      4'h9:                     s = 3'd5;
      4'hE, 4'hF:               s = 3'd7;
      default:                  s = 3'd6;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/fsg_sector_decode.sv
module fsg_sector_decode
  import fsg_pkg::*;
#(
  parameter int TOP_BOOT = 0,
  parameter int ADDR_W   = WORD_ADDR_W,
  parameter int IDX_W    = SECT_IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              plane_b
);
  localparam int HI_W        = ADDR_W - SMALL_AREA_W;
  localparam int BIG_W       = ADDR_W - BIG_SECT_W;
  localparam int BIG_PER_AREA = 2 ** (SMALL_AREA_W - BIG_SECT_W);
  localparam int SMALL_COUNT = 8;
  localparam int BIG_COUNT   = 2 ** BIG_W - BIG_PER_AREA;

  logic [HI_W-1:0]  area;
  logic [BIG_W-1:0] big;
  logic [2:0]       slot;
  logic             in_small;

  assign area = addr[ADDR_W-1:SMALL_AREA_W];
  assign big  = addr[ADDR_W-1:BIG_SECT_W];
  assign slot = small_slot(addr[SMALL_AREA_W-1:ID_OFS_W]);

  generate
    if (TOP_BOOT != 0) begin : g_top
      assign in_small = (area == {HI_W{1'b1}});
      assign idx = in_small ? IDX_W'(BIG_COUNT) + IDX_W'(slot) : IDX_W'(big);
    end else begin : g_bottom
      assign in_small = (area == '0);
      assign idx = in_small ? IDX_W'(slot)
                            : IDX_W'(big) + IDX_W'(SMALL_COUNT - BIG_PER_AREA);
    end
  endgenerate

  assign plane_b = !in_small;

endmodule

// File: rtl/fsg_lock_bank.sv
module fsg_lock_bank
  import fsg_pkg::*;
#(
  parameter int N     = NUM_SECTORS,
  parameter int IDX_W = SECT_IDX_W
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  output logic [N-1:0]     lock_q
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                                   lock_q[i] <= 1'b0;
        else if (set_en && (set_idx == IDX_W'(i)))    lock_q[i] <= 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/fsg_id_mux.sv
module fsg_id_mux
  import fsg_pkg::*;
#(
  parameter logic [ID_W-1:0] DEV_CODE = DEV_CODE_BOT
) (
  input  logic [ID_OFS_W-1:0] offset,
  input  logic                lock_bit,
  output logic [ID_W-1:0]     data
);
  always_comb begin
    case (offset)
      ID_OFS_W'(0): data = MFR_CODE;
      ID_OFS_W'(1): data = DEV_CODE;
      ID_OFS_W'(2): data = {{(ID_W-1){1'b0}}, lock_bit};
      default:      data = '0;
    endcase
  end
endmodule

// File: rtl/flash_sector_guard.sv
module flash_sector_guard
  import fsg_pkg::*;
#(
  parameter int TOP_BOOT = 0
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [2:0]             req_op,
  input  logic [WORD_ADDR_W-1:0] req_addr,
  input  logic                   hv_override,
  output logic                   rsp_valid,
  output logic [SECT_IDX_W-1:0]  rsp_sector,
  output logic                   rsp_plane,
  output logic                   rsp_permit,
  output logic                   rsp_quick_abort,
  output logic [NUM_SECTORS-1:0] rsp_erase_mask,
  output logic [ID_W-1:0]        rsp_id_data
);
  localparam logic [ID_W-1:0] DEV_CODE = (TOP_BOOT != 0) ? DEV_CODE_TOP : DEV_CODE_BOT;

  logic [SECT_IDX_W-1:0]  sec_idx;
  logic                   sec_plane_b;
  logic [NUM_SECTORS-1:0] lock_q;
  logic [ID_W-1:0]        id_word;
  logic                   sec_locked;
  logic                   lock_set;
  logic                   any_rst_n;

  logic                   nx_permit;
  logic                   nx_abort;
  logic [NUM_SECTORS-1:0] nx_mask;
  logic [NUM_SECTORS-1:0] own_bit;
  logic [NUM_SECTORS-1:0] free_mask;
  logic [ID_W-1:0]        nx_id;

  assign any_rst_n = rst_n & por_n;

  fsg_sector_decode #(.TOP_BOOT(TOP_BOOT)) u_decode (
    .addr    (req_addr),
    .idx     (sec_idx),
    .plane_b (sec_plane_b)
  );

  assign lock_set = req_valid && (req_op == OP_LOCK);

  fsg_lock_bank u_locks (
    .clk     (clk),
    .por_n   (por_n),
    .set_en  (lock_set),
    .set_idx (sec_idx),
    .lock_q  (lock_q)
  );

  assign sec_locked = lock_q[sec_idx];

  fsg_id_mux #(.DEV_CODE(DEV_CODE)) u_id (
    .offset   (req_addr[ID_OFS_W-1:0]),
    .lock_bit (sec_locked),
    .data     (id_word)
  );

  assign own_bit   = NUM_SECTORS'(1) << sec_idx;
  assign free_mask = hv_override ? {NUM_SECTORS{1'b1}} : ~lock_q;

  always_comb begin
    nx_permit = 1'b0;
    nx_abort  = 1'b0;
    nx_mask   = '0;
    nx_id     = '0;
    case (req_op)
      OP_PROG: nx_permit = !sec_locked || hv_override;
      OP_SERASE: begin
        nx_permit = !sec_locked || hv_override;
        nx_abort  = !nx_permit;
        nx_mask   = nx_permit ? own_bit : '0;
      end
      OP_CERASE: begin
        nx_mask   = free_mask;
        nx_permit = |free_mask;
      end
      OP_LOCK: nx_permit = 1'b1;
      OP_IDRD: nx_id     = id_word;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge any_rst_n) begin
    if (!any_rst_n) begin
      rsp_valid       <= 1'b0;
      rsp_sector      <= '0;
      rsp_plane       <= 1'b0;
      rsp_permit      <= 1'b0;
      rsp_quick_abort <= 1'b0;
      rsp_erase_mask  <= '0;
      rsp_id_data     <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_sector      <= sec_idx;
        rsp_plane       <= sec_plane_b;
        rsp_permit      <= nx_permit;
        rsp_quick_abort <= nx_abort;
        rsp_erase_mask  <= nx_mask;
        rsp_id_data     <= nx_id;
      end else begin
        rsp_permit      <= 1'b0;
        rsp_quick_abort <= 1'b0;
        rsp_erase_mask  <= '0;
      end
    end
  end

endmodule

// File: rtl/fsg_guard_chk.sv
module fsg_guard_chk
  import fsg_pkg::*;
#(
  parameter int TOP_BOOT = 0
) (
  input logic                   clk,
  input logic                   por_n,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic [2:0]             req_op,
  input logic                   hv_override,
  input logic                   rsp_valid,
  input logic [SECT_IDX_W-1:0]  rsp_sector,
  input logic                   rsp_plane,
  input logic                   rsp_permit,
  input logic                   rsp_quick_abort,
  input logic [NUM_SECTORS-1:0] rsp_erase_mask,
  input logic [NUM_SECTORS-1:0] lock_q
);
  localparam int FIRST_SMALL = (TOP_BOOT != 0) ? 14 : 0;

  logic [NUM_SECTORS-1:0] lock_d;
  logic [2:0]             op_d;
  logic                   hv_d;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lock_d <= '0;
      op_d   <= 3'd0;
      hv_d   <= 1'b0;
    end else begin
      lock_d <= lock_q;
      op_d   <= req_op;
      hv_d   <= hv_override;
    end
  end

  p_resp_follows_r4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    req_valid |=> rsp_valid);

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !req_valid |=> !rsp_valid);

  p_plane_split_r2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    rsp_valid |-> (rsp_plane == !((int'(rsp_sector) >= FIRST_SMALL) &&
                                  (int'(rsp_sector) < FIRST_SMALL + 8))));

  p_locked_refused_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (rsp_valid && (op_d == OP_PROG || op_d == OP_SERASE) && !hv_d && lock_d[rsp_sector])
      |-> !rsp_permit);

  p_override_grants_r6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (rsp_valid && (op_d == OP_PROG || op_d == OP_SERASE) && hv_d) |-> rsp_permit);

  p_mask_spares_locked_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (rsp_valid && !hv_d) |-> ((rsp_erase_mask & lock_d) == '0));

  p_abort_clean_r8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    rsp_quick_abort |-> (!rsp_permit && rsp_erase_mask == '0));

  p_serase_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (rsp_valid && op_d == OP_SERASE) |-> $onehot0(rsp_erase_mask));

  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!por_n)
    ($past(lock_q) & ~lock_q) == '0);

endmodule

bind flash_sector_guard fsg_guard_chk #(.TOP_BOOT(TOP_BOOT)) u_chk (
  .clk             (clk),
  .por_n           (por_n),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_op          (req_op),
  .hv_override     (hv_override),
  .rsp_valid       (rsp_valid),
  .rsp_sector      (rsp_sector),
  .rsp_plane       (rsp_plane),
  .rsp_permit      (rsp_permit),
  .rsp_quick_abort (rsp_quick_abort),
  .rsp_erase_mask  (rsp_erase_mask),
  .lock_q          (lock_q)
);

// File: tb/test_flash_sector_guard.sv
module test_flash_sector_guard;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [18:0] req_addr = '0;
  logic        hv_override = 1'b0;

  logic        rsp_valid, t_valid;
  logic [4:0]  rsp_sector, t_sector;
  logic        rsp_plane, t_plane;
  logic        rsp_permit, t_permit;
  logic        rsp_abort, t_abort;
  logic [21:0] rsp_mask, t_mask;
  logic [15:0] rsp_id, t_id;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_sector_guard #(.TOP_BOOT(0)) i_flash_sector_guard (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .hv_override(hv_override), .rsp_valid(rsp_valid),
    .rsp_sector(rsp_sector), .rsp_plane(rsp_plane), .rsp_permit(rsp_permit),
    .rsp_quick_abort(rsp_abort), .rsp_erase_mask(rsp_mask), .rsp_id_data(rsp_id)
  );

  flash_sector_guard #(.TOP_BOOT(1)) i_flash_sector_guard_top (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .hv_override(hv_override), .rsp_valid(t_valid),
    .rsp_sector(t_sector), .rsp_plane(t_plane), .rsp_permit(t_permit),
    .rsp_quick_abort(t_abort), .rsp_erase_mask(t_mask), .rsp_id_data(t_id)
  );

  // {op, addr, sector, plane, permit, id}
  localparam int NV = 19;
  localparam logic [44:0] VEC [NV] = '{
    {3'd1, 19'h00000, 5'd0,  1'b0, 1'b1, 16'h0000},
    {3'd1, 19'h01FFF, 5'd0,  1'b0, 1'b1, 16'h0000},
    {3'd2, 19'h02000, 5'd1,  1'b0, 1'b1, 16'h0000},
    {3'd1, 19'h05FFF, 5'd1,  1'b0, 1'b1, 16'h0000},
    {3'd1, 19'h06000, 5'd2,  1'b0, 1'b1, 16'h0000},
    {3'd1, 19'h07ABC, 5'd3,  1'b0, 1'b1, 16'h0000},
    {3'd1, 19'h08000, 5'd4,  1'b0, 1'b1, 16'h0000},
    {3'd1, 19'h09FFF, 5'd5,  1'b0, 1'b1, 16'h0000},
    {3'd1, 19'h0A000, 5'd6,  1'b0, 1'b1, 16'h0000},
    {3'd1, 19'h0E000, 5'd7,  1'b0, 1'b1, 16'h0000},
    {3'd1, 19'h0FFFF, 5'd7,  1'b0, 1'b1, 16'h0000},
    {3'd1, 19'h10000, 5'd8,  1'b1, 1'b1, 16'h0000},
    {3'd2, 19'h17FFF, 5'd8,  1'b1, 1'b1, 16'h0000},
    {3'd1, 19'h18000, 5'd9,  1'b1, 1'b1, 16'h0000},
    {3'd1, 19'h7FFFF, 5'd21, 1'b1, 1'b1, 16'h0000},
    {3'd5, 19'h00000, 5'd0,  1'b0, 1'b0, 16'h001F},
    {3'd5, 19'h10001, 5'd8,  1'b1, 1'b0, 16'h00CB},
    {3'd5, 19'h06002, 5'd2,  1'b0, 1'b0, 16'h0000},
    {3'd5, 19'h0A003, 5'd6,  1'b0, 1'b0, 16'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, let the rising edge register, return at the next falling edge.
  task automatic issue(input logic [2:0] op, input logic [18:0] a, input logic hv);
    req_op = op; req_addr = a; hv_override = hv; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; hv_override = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 valid in reset", {31'd0, rsp_valid}, 32'd0);
    chk("R11 permit in reset", {31'd0, rsp_permit}, 32'd0);
    chk("R11 mask in reset", {10'd0, rsp_mask}, 32'd0);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R4 R9: decode table on the bottom-boot build
    for (int i = 0; i < NV; i++) begin
      logic [44:0] v;
      v = VEC[i];
      issue(v[44:42], v[41:23], 1'b0);
      chk($sformatf("R4 valid vec %0d", i), {31'd0, rsp_valid}, 32'd1);
      chk($sformatf("R1 sector vec %0d", i), {27'd0, rsp_sector}, {27'd0, v[22:18]});
      chk($sformatf("R2 plane vec %0d", i), {31'd0, rsp_plane}, {31'd0, v[17]});
      chk($sformatf("R9 permit vec %0d", i), {31'd0, rsp_permit}, {31'd0, v[16]});
      chk($sformatf("R9 id vec %0d", i), {16'd0, rsp_id}, {16'd0, v[15:0]});
    end
    @(negedge clk);
    chk("R4 idle valid", {31'd0, rsp_valid}, 32'd0);

    // R5: lock sector 3
    issue(3'd4, 19'h07000, 1'b0);
    chk("R5 lock permit", {31'd0, rsp_permit}, 32'd1);
    issue(3'd1, 19'h07010, 1'b0);
    chk("R5 prog locked", {31'd0, rsp_permit}, 32'd0);
    issue(3'd1, 19'h08000, 1'b0);
    chk("R5 prog neighbour", {31'd0, rsp_permit}, 32'd1);
    // R8
    issue(3'd2, 19'h07000, 1'b0);
    chk("R8 serase locked permit", {31'd0, rsp_permit}, 32'd0);
    chk("R8 serase locked abort", {31'd0, rsp_abort}, 32'd1);
    chk("R8 serase locked mask", {10'd0, rsp_mask}, 32'd0);
    issue(3'd2, 19'h08000, 1'b0);
    chk("R8 serase free mask", {10'd0, rsp_mask}, 32'h10);
    chk("R8 serase free abort", {31'd0, rsp_abort}, 32'd0);
    // R6
    issue(3'd1, 19'h07010, 1'b1);
    chk("R6 prog override", {31'd0, rsp_permit}, 32'd1);
    issue(3'd2, 19'h07000, 1'b1);
    chk("R6 serase override mask", {10'd0, rsp_mask}, 32'h8);
    // R9 lock readback
    issue(3'd5, 19'h07002, 1'b0);
    chk("R9 lock bit readback", {16'd0, rsp_id}, 32'h0001);

    // R7: chip erase with sectors 3 and 21 locked
    issue(3'd4, 19'h7FFFF, 1'b0);
    issue(3'd3, 19'h05555, 1'b0);
    chk("R7 chip mask", {10'd0, rsp_mask}, 32'h1FFFF7);
    chk("R7 chip permit", {31'd0, rsp_permit}, 32'd1);
    issue(3'd3, 19'h05555, 1'b1);
    chk("R7 chip mask override", {10'd0, rsp_mask}, 32'h3FFFFF);

    // R12: undefined code
    issue(3'd7, 19'h09000, 1'b0);
    chk("R12 permit", {31'd0, rsp_permit}, 32'd0);
    chk("R12 mask", {10'd0, rsp_mask}, 32'd0);
    issue(3'd5, 19'h09002, 1'b0);
    chk("R12 no lock", {16'd0, rsp_id}, 32'h0000);

    // R10: ordinary reset keeps locks
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 valid in rst", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(3'd5, 19'h07002, 1'b0);
    chk("R10 lock after rst", {16'd0, rsp_id}, 32'h0001);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    issue(3'd5, 19'h07002, 1'b0);
    chk("R10 lock after por", {16'd0, rsp_id}, 32'h0000);
    issue(3'd1, 19'h07000, 1'b0);
    chk("R10 prog after por", {31'd0, rsp_permit}, 32'd1);

    // R3: top-boot build
    issue(3'd1, 19'h00000, 1'b0);
    chk("R3 top 00000 sector", {27'd0, t_sector}, 32'd0);
    chk("R3 top 00000 plane", {31'd0, t_plane}, 32'd1);
    issue(3'd1, 19'h6FFFF, 1'b0);
    chk("R3 top 6FFFF sector", {27'd0, t_sector}, 32'd13);
    issue(3'd1, 19'h70000, 1'b0);
    chk("R3 top 70000 sector", {27'd0, t_sector}, 32'd14);
    chk("R3 top 70000 plane", {31'd0, t_plane}, 32'd0);
    issue(3'd1, 19'h72000, 1'b0);
    chk("R3 top 72000 sector", {27'd0, t_sector}, 32'd15);
    issue(3'd1, 19'h76000, 1'b0);
    chk("R3 top 76000 sector", {27'd0, t_sector}, 32'd16);
    issue(3'd1, 19'h79000, 1'b0);
    chk("R3 top 79000 sector", {27'd0, t_sector}, 32'd19);
    issue(3'd1, 19'h7A000, 1'b0);
    chk("R3 top 7A000 sector", {27'd0, t_sector}, 32'd20);
    issue(3'd1, 19'h7FFFF, 1'b0);
    chk("R3 top 7FFFF sector", {27'd0, t_sector}, 32'd21);
    issue(3'd5, 19'h70001, 1'b0);
    chk("R3 top device code", {16'd0, t_id}, 32'h004A);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule